// File: doc/BRIEF.md
# Resonance-Minimizing Clock Period Selector

This block picks the clock period for the next operating window from a short list of permitted periods. The goal is to keep the supply current from exciting the resonance between the on-chip capacitance and the package inductance, which sits somewhere between 50 and 200 MHz, far below the core clock. A predictor upstream supplies the expected peak current for each of the next `NWIN` cycles. Each cycle's current is treated as a triangular pulse with equal rise and fall times, scaled by its peak. For every candidate period the block evaluates one spectral bin of that reconstructed waveform at the resonance frequency, and it returns the index of the candidate whose bin is smallest.

Candidates are evaluated one after another. Each cycle uses one multiply-accumulate pair, one for the real part and one for the imaginary part. Per candidate and per window slot, the caller provides precomputed cosine and sine table entries for the phase `w0·n·T`. Per candidate, it provides a gain that folds in the triangle shape's response at resonance. The block compares squared magnitudes, so no square root is needed. Candidate index 0 must hold the shortest period, and indices increase with period. Programming the clock generator and sensing the current are done elsewhere.

Top module: `res_period_sel`

## Requirements
- R1: For each considered candidate c the block forms re = Σn P(n)·C(c,n) and im = −Σn P(n)·S(c,n), and the metric G(c)²·(re²+im²). On `done_o` it reports in `sel_o` the index with the smallest metric.
- R2: When two or more candidates share the smallest metric, the lowest index wins, which is the shortest period.
- R3: `n_cand_i` is sampled on the accepted start edge. A value of 0 counts as 1, and a value above `NCAND` counts as `NCAND`. Only indices below that count are considered.
- R4: `done_o` is a one-cycle pulse. It rises exactly count·(`NWIN`+1) clock edges after the edge that accepts `start_i`.
- R5: A `start_i` seen while an evaluation is running is ignored. It is not queued and does not change the result or the timing.
- R6: `sel_o` changes only together with a `done_o` pulse (or at reset) and holds its value in between.
- R7: A synchronous active-low reset drives `sel_o` to 0 and `done_o` to 0, and it abandons any running evaluation without a later `done_o`.
- R8: The peaks are captured on the accepted start edge. Changes of `peaks_i` afterwards do not affect the running result. The tables and gains must stay static while the evaluation runs.
- R9: Field layout is as follows. Peak n is unsigned `IW` bits at `peaks_i[n*IW +: IW]`. The table entry for (c,n) is signed two's complement `TW` bits at `[(c*NWIN+n)*TW +: TW]` of the cosine and sine buses. Gain c is unsigned `GW` bits at `gain_i[c*GW +: GW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| n_cand_i | input | CNTW | Number of candidates to consider |
| peaks_i | input | NWIN*IW | Predicted peak current per window slot |
| cos_tab_i | input | NCAND*NWIN*TW | Cosine of resonance phase per candidate and slot |
| sin_tab_i | input | NCAND*NWIN*TW | Sine of resonance phase per candidate and slot |
| gain_i | input | NCAND*GW | Triangle-shape gain per candidate |
| sel_o | output | CIW | Selected candidate index |
| done_o | output | 1 | One-cycle pulse when `sel_o` is updated |

## Verification
Exact metric ties are hard to produce with realistic table contents, because products of random peaks and trigonometric entries almost never coincide. The stimulus forces ties in two ways. It zeroes the gain of two non-adjacent candidates, which gives both a metric of zero. It also zeroes all peaks, which makes every metric equal. Both cases expose the tie rule directly. A second strobe arriving mid-run together with changed peaks is driven at a fixed offset. The bench then checks that the answer and the latency match the first request and that no second pulse follows.

// File: rtl/res_period_sel_pkg.sv
// Shared types for the resonance period selector.
package res_period_sel_pkg;
    // Controller phases: idle, accumulating one candidate, comparing its metric.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_CMP  = 2'd2
    } rps_state_e;
endpackage

// File: rtl/res_period_cmac.sv
// Complex multiply-accumulate for one spectral bin.
// Adds peak*cos to the real sum and subtracts peak*sin from the imaginary sum
// each enabled cycle. Assumes AW leaves room for NWIN terms.
module res_period_cmac #(
    parameter int IW = 8,
    parameter int TW = 10,
    parameter int AW = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic [IW-1:0]        peak_i,
    input  logic signed [TW-1:0] cos_i,
    input  logic signed [TW-1:0] sin_i,
    output logic signed [AW-1:0] re_o,
    output logic signed [AW-1:0] im_o
);
    localparam int PW = IW + 1 + TW;

    logic signed [PW-1:0] prod_c;
    logic signed [PW-1:0] prod_s;
    logic signed [AW-1:0] ext_c;
    logic signed [AW-1:0] ext_s;

    // Form the two products with the peak treated as a non-negative signed value.
    always_comb begin
        prod_c = $signed({1'b0, peak_i}) * cos_i;
        prod_s = $signed({1'b0, peak_i}) * sin_i;
        ext_c  = {{(AW-PW){prod_c[PW-1]}}, prod_c};
        ext_s  = {{(AW-PW){prod_s[PW-1]}}, prod_s};
    end

    // Accumulate, or restart from zero for a new candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            re_o <= '0;
            im_o <= '0;
        end else if (en_i) begin
            re_o <= re_o + ext_c;
            im_o <= im_o - ext_s;
        end
    end
endmodule

// File: rtl/res_period_metric.sv
// Squared bin magnitude scaled by the squared triangle gain.
// Purely combinational; assumes MW = 2*AW + 1 + 2*GW.
module res_period_metric #(
    parameter int AW = 22,
    parameter int GW = 4,
    parameter int MW = 2*AW + 1 + 2*GW
) (
    input  logic signed [AW-1:0] re_i,
    input  logic signed [AW-1:0] im_i,
    input  logic [GW-1:0]        gain_i,
    output logic [MW-1:0]        metric_o
);
    logic signed [2*AW-1:0] sq_re;
    logic signed [2*AW-1:0] sq_im;
    logic [2*AW:0]          pow;
    logic [2*GW-1:0]        g2;

    // Squares are non-negative, so their sum is taken as unsigned.
    always_comb begin
        sq_re    = re_i * re_i;
        sq_im    = im_i * im_i;
        pow      = {1'b0, sq_re} + {1'b0, sq_im};
        g2       = gain_i * gain_i;
        metric_o = MW'(pow) * MW'(g2);
    end
endmodule

// File: rtl/res_period_argmin.sv
// Running minimum tracker over candidate metrics.
// A strictly smaller metric replaces the best, so ties keep the lower index.
// Assumes candidates arrive in increasing index order, the first flagged.
module res_period_argmin #(
    parameter int MW  = 53,
    parameter int CIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_i,
    input  logic           first_i,
    input  logic [CIW-1:0] idx_i,
    input  logic [MW-1:0]  metric_i,
    output logic [CIW-1:0] best_nxt_o
);
    logic [MW-1:0]  best_m_q;
    logic [CIW-1:0] best_i_q;
    logic           take;

    // Decide whether the presented candidate becomes the best so far.
    always_comb begin
        take       = first_i || (metric_i < best_m_q);
        best_nxt_o = take ? idx_i : best_i_q;
    end

    // Store the best metric and index on each comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_m_q <= '0;
            best_i_q <= '0;
        end else if (upd_i && take) begin
            best_m_q <= metric_i;
            best_i_q <= idx_i;
        end
    end
endmodule

// File: rtl/res_period_sel.sv
// Resonance-minimizing clock period selector (top).
// On an accepted start, captures the peaks and the candidate count, then for
// each candidate accumulates NWIN terms of one spectral bin (one cycle each)
// and compares the gain-scaled squared magnitude in one further cycle.
// Assumes index 0 is the shortest period and that the tables and gains stay
// static during a run.
module res_period_sel
    import res_period_sel_pkg::*;
#(
    parameter int NCAND = 8,
    parameter int NWIN  = 7,
    parameter int IW    = 8,
    parameter int TW    = 10,
    parameter int GW    = 4,
    localparam int CIW  = $clog2(NCAND),
    localparam int CNTW = $clog2(NCAND + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [CNTW-1:0]             n_cand_i,
    input  logic [NWIN*IW-1:0]          peaks_i,
    input  logic [NCAND*NWIN*TW-1:0]    cos_tab_i,
    input  logic [NCAND*NWIN*TW-1:0]    sin_tab_i,
    input  logic [NCAND*GW-1:0]         gain_i,
    output logic [CIW-1:0]              sel_o,
    output logic                        done_o
);
    localparam int NIW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int AW  = IW + TW + 1 + $clog2(NWIN + 1);
    localparam int MW  = 2*AW + 1 + 2*GW;

    rps_state_e            state_q;
    logic [CIW-1:0]        cand_q;
    logic [NIW-1:0]        n_q;
    logic [CNTW-1:0]       cnt_q;
    logic [IW-1:0]         peaks_q [NWIN];

    logic                  accept;
    logic                  last_n;
    logic                  last_c;
    logic [CNTW-1:0]       cnt_clamp;
    logic [IW-1:0]         peak_cur;
    logic signed [TW-1:0]  cos_cur;
    logic signed [TW-1:0]  sin_cur;
    logic [GW-1:0]         gain_cur;
    logic signed [AW-1:0]  acc_re;
    logic signed [AW-1:0]  acc_im;
    logic [MW-1:0]         metric;
    logic [CIW-1:0]        best_nxt;

    // Start acceptance, loop-end flags and candidate count clamping.
    always_comb begin
        accept = start_i && (state_q == ST_IDLE);
        last_n = (n_q == NIW'(NWIN - 1));
        last_c = (CNTW'(cand_q) == cnt_q - 1'b1);
        if (n_cand_i == '0)
            cnt_clamp = CNTW'(1);
        else if (n_cand_i > CNTW'(NCAND))
            cnt_clamp = CNTW'(NCAND);
        else
            cnt_clamp = n_cand_i;
    end

    // Select the operands for the current candidate and window slot.
    always_comb begin
        int base;
        base     = int'(cand_q) * NWIN + int'(n_q);
        peak_cur = peaks_q[n_q];
        cos_cur  = cos_tab_i[base*TW +: TW];
        sin_cur  = sin_tab_i[base*TW +: TW];
        gain_cur = gain_i[int'(cand_q)*GW +: GW];
    end

    // Capture the window peaks on an accepted start.
    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_peak
            always_ff @(posedge clk) begin
                if (!rst_n)
                    peaks_q[g] <= '0;
                else if (accept)
                    peaks_q[g] <= peaks_i[g*IW +: IW];
            end
        end
    endgenerate

    // Sequence slots and candidates: NWIN accumulate cycles, then one compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            n_q     <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_ACC;
                    cand_q  <= '0;
                    n_q     <= '0;
                    cnt_q   <= cnt_clamp;
                end
                ST_ACC: begin
                    n_q <= last_n ? '0 : n_q + 1'b1;
                    if (last_n)
                        state_q <= ST_CMP;
                end
                ST_CMP: begin
                    if (last_c) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_ACC;
                        cand_q  <= cand_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    res_period_cmac #(.IW(IW), .TW(TW), .AW(AW)) u_cmac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept || (state_q == ST_CMP)),
        .en_i   (state_q == ST_ACC),
        .peak_i (peak_cur),
        .cos_i  (cos_cur),
        .sin_i  (sin_cur),
        .re_o   (acc_re),
        .im_o   (acc_im)
    );

    res_period_metric #(.AW(AW), .GW(GW), .MW(MW)) u_metric (
        .re_i     (acc_re),
        .im_i     (acc_im),
        .gain_i   (gain_cur),
        .metric_o (metric)
    );

    res_period_argmin #(.MW(MW), .CIW(CIW)) u_argmin (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (state_q == ST_CMP),
        .first_i    (cand_q == '0),
        .idx_i      (cand_q),
        .metric_i   (metric),
        .best_nxt_o (best_nxt)
    );

    // Publish the winner and pulse done after the last comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_CMP && last_c) begin
                sel_o  <= best_nxt;
                done_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/res_period_sel_chk.sv
// Protocol checker for the period selector, bound to the top module.
// Keeps its own model of the run state and cycle count from the ports.
module res_period_sel_chk #(
    parameter int NCAND = 8,
    parameter int NWIN  = 7,
    localparam int CIW  = $clog2(NCAND),
    localparam int CNTW = $clog2(NCAND + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [CNTW-1:0] n_cand_i,
    input logic [CIW-1:0]  sel_o,
    input logic            done_o
);
    logic            busy_q;
    logic [15:0]     cyc_q;
    logic [CNTW-1:0] cnt_q;
    logic [15:0]     exp_cyc;

    // Expected run length for the captured candidate count.
    always_comb exp_cyc = 16'(cnt_q) * 16'(NWIN + 1);

    // Track a run from an accepted start to its done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            cnt_q  <= '0;
        end else if (start_i && (!busy_q || done_o)) begin
            busy_q <= 1'b1;
            cyc_q  <= '0;
            cnt_q  <= (n_cand_i == '0) ? CNTW'(1)
                    : (n_cand_i > CNTW'(NCAND)) ? CNTW'(NCAND) : n_cand_i;
        end else if (busy_q) begin
            cyc_q <= cyc_q + 16'd1;
            if (done_o)
                busy_q <= 1'b0;
        end
    end

    // R4: done lasts a single cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4 and R5: done only ends a tracked run, after exactly count*(NWIN+1) edges
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && cyc_q == exp_cyc));

    // R3: the reported index lies below the captured count
    p_sel_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (CNTW'(sel_o) < cnt_q));

    // R6: the selection holds between done pulses
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done_o) |-> $stable(sel_o));

    // R7: reset clears the outputs
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!done_o && sel_o == '0));
endmodule

bind res_period_sel res_period_sel_chk #(.NCAND(NCAND), .NWIN(NWIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .n_cand_i (n_cand_i),
    .sel_o    (sel_o),
    .done_o   (done_o)
);

// File: tb/res_period_sel_tb.sv
`timescale 1ns/1ps
module res_period_sel_tb;
    localparam int NCAND = 8;
    localparam int NWIN  = 7;
    localparam int IW    = 8;
    localparam int TW    = 10;
    localparam int GW    = 4;
    localparam int CIW   = $clog2(NCAND);
    localparam int CNTW  = $clog2(NCAND + 1);

    // Vector table: seed, requested count, expected latency in edges (count*(NWIN+1)+1)
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{11,  8, 65}, '{23, 5, 41}, '{37, 3, 25},
        '{41,  1,  9}, '{59, 8, 65}, '{73, 2, 17}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [CNTW-1:0]          n_cand = '0;
    logic [NWIN*IW-1:0]       peaks;
    logic [NCAND*NWIN*TW-1:0] cos_tab;
    logic [NCAND*NWIN*TW-1:0] sin_tab;
    logic [NCAND*GW-1:0]      gain;
    logic [CIW-1:0]           sel;
    logic                     done;

    int pk [NWIN];
    int cs [NCAND][NWIN];
    int sn [NCAND][NWIN];
    int gn [NCAND];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    res_period_sel #(.NCAND(NCAND), .NWIN(NWIN), .IW(IW), .TW(TW), .GW(GW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .n_cand_i  (n_cand),
        .peaks_i   (peaks),
        .cos_tab_i (cos_tab),
        .sin_tab_i (sin_tab),
        .gain_i    (gain),
        .sel_o     (sel),
        .done_o    (done)
    );

    // Pack the bench arrays into the R9 field layout.
    always_comb begin
        for (int n = 0; n < NWIN; n++) peaks[n*IW +: IW] = IW'(pk[n]);
        for (int c = 0; c < NCAND; c++) begin
            gain[c*GW +: GW] = GW'(gn[c]);
            for (int n = 0; n < NWIN; n++) begin
                cos_tab[(c*NWIN+n)*TW +: TW] = TW'(cs[c][n]);
                sin_tab[(c*NWIN+n)*TW +: TW] = TW'(sn[c][n]);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R4 watchdog expired: actual %0d cycles, expected fewer", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pseudo-random fill of peaks, tables and gains from a seed.
    task automatic fill(input int seed);
        logic [31:0] s;
        s = 32'(seed);
        for (int n = 0; n < NWIN; n++) begin
            s = s * 32'd1103515245 + 32'd12345;
            pk[n] = int'(s[23:16]);
        end
        for (int c = 0; c < NCAND; c++) begin
            s = s * 32'd1103515245 + 32'd12345;
            gn[c] = 1 + int'(s[19:16]) % 15;
            for (int n = 0; n < NWIN; n++) begin
                s = s * 32'd1103515245 + 32'd12345;
                cs[c][n] = int'(s[25:16]) - 512;
                s = s * 32'd1103515245 + 32'd12345;
                sn[c][n] = int'(s[25:16]) - 512;
            end
        end
    endtask

    // Reference metric from R1.
    function automatic longint ref_metric(input int c);
        longint re, im;
        re = 0; im = 0;
        for (int n = 0; n < NWIN; n++) begin
            re += longint'(pk[n]) * longint'(cs[c][n]);
            im -= longint'(pk[n]) * longint'(sn[c][n]);
        end
        return (re*re + im*im) * longint'(gn[c]) * longint'(gn[c]);
    endfunction

    // Reference selection with R2 tie rule and R3 clamping.
    function automatic int ref_sel(input int req);
        int cnt, best;
        longint bm, m;
        cnt  = (req == 0) ? 1 : (req > NCAND ? NCAND : req);
        best = 0;
        bm   = ref_metric(0);
        for (int c = 1; c < cnt; c++) begin
            m = ref_metric(c);
            if (m < bm) begin bm = m; best = c; end
        end
        return best;
    endfunction

    // Pulse start and count edges until done is seen (sampled at negedge).
    task automatic run_eval(input int req, output int lat);
        n_cand = CNTW'(req);
        start  = 1'b1;
        lat    = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (done || lat > 700) break;
        end
    endtask

    int lat;
    int exp_s;
    bit seen;

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        // R7: reset state
        check(sel == '0, "R7", "sel after reset", sel, 0);
        check(done == 1'b0, "R7", "done after reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R4, R9: vector table walk
        for (int v = 0; v < NVEC; v++) begin
            fill(VEC[v][0]);
            exp_s = ref_sel(VEC[v][1]);
            run_eval(VEC[v][1], lat);
            check(int'(sel) == exp_s, "R1", "selected index", sel, exp_s);
            check(lat == VEC[v][2], "R4", "done latency", lat, VEC[v][2]);
            @(negedge clk);
            check(done == 1'b0, "R4", "done single cycle", done, 0);
        end

        // R2: two zero-gain candidates tie at zero; lower index wins
        fill(101);
        gn[3] = 0; gn[6] = 0;
        run_eval(8, lat);
        check(sel == CIW'(3), "R2", "tie between 3 and 6", sel, 3);

        // R2: all peaks zero, every metric equal
        for (int n = 0; n < NWIN; n++) pk[n] = 0;
        gn[3] = 5; gn[6] = 5;
        run_eval(8, lat);
        check(sel == '0, "R2", "all-equal tie", sel, 0);

        // R3: count 0 acts as 1
        fill(202);
        gn[0] = 9; gn[4] = 0;
        run_eval(0, lat);
        check(sel == '0, "R3", "count zero index", sel, 0);
        check(lat == 9, "R3", "count zero latency", lat, 9);

        // R3: count above NCAND clamps
        fill(303);
        exp_s = ref_sel(12);
        run_eval(12, lat);
        check(int'(sel) == exp_s, "R3", "clamped count index", sel, exp_s);
        check(lat == 65, "R3", "clamped count latency", lat, 65);

        // R3: a zero-gain candidate beyond the count is not considered
        fill(404);
        gn[5] = 0;
        exp_s = ref_sel(3);
        run_eval(3, lat);
        check(int'(sel) == exp_s, "R3", "index limited by count", sel, exp_s);

        // R5, R8: restart and peak change mid-run are ignored
        fill(505);
        gn[2] = 0;
        exp_s = ref_sel(8);
        n_cand = CNTW'(8);
        start  = 1'b1;
        lat    = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (lat == 6) begin
                for (int n = 0; n < NWIN; n++) pk[n] = 0;
                n_cand = CNTW'(1);
                start  = 1'b1;
            end
            if (done || lat > 700) break;
        end
        check(int'(sel) == exp_s, "R8", "result uses captured peaks", sel, exp_s);
        check(lat == 65, "R5", "latency with mid-run strobe", lat, 65);

        // R5, R6: no queued run, selection held
        seen = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen == 1'b0, "R5", "no second done", seen, 0);
        check(int'(sel) == exp_s, "R6", "selection held", sel, exp_s);

        // R7: reset during a run abandons it
        fill(606);
        gn[0] = 15; gn[7] = 0;
        run_eval(8, lat);
        check(sel == CIW'(ref_sel(8)), "R1", "index before reset test", sel, ref_sel(8));
        n_cand = CNTW'(8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(sel == '0, "R7", "sel after mid-run reset", sel, 0);
        check(done == 1'b0, "R7", "done after mid-run reset", done, 0);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen == 1'b0, "R7", "abandoned run stays silent", seen, 0);

        finish_run();
    end
endmodule